// File: doc/BRIEF.md
# Virtually Indexed Write-Through Line Cache

This block is a direct-mapped cache that sits between a processor request port and a simple word-wide main-memory port. It is indexed and tagged by the virtual address. Each line carries a context number, a valid flag and two permission flags taken from the page mapping. Reads that hit are served from the line store. Reads that miss refill the whole line from memory. Every store is passed on to memory. A store that hits also updates the cached bytes. A store that misses evicts whatever line occupies that index and does not allocate.

Software manages the cache through a control port. It can read and write each tag as a 32-bit word and set the enable flag. After reset the enable flag is clear, and software must zero every tag before it sets the flag. A flush engine walks the whole tag array, one index per clock. It drops the valid flag of lines that belong to a chosen context and, depending on the selected mode, to a given segment or page of that context. Processor requests wait while the engine runs.

The address splits into a byte offset (OFS_W bits, 16-byte lines), a line index (IDX_W bits) and a 14-bit tag ID above them. For flush matching, a line's virtual address is rebuilt as tag ID, then index, then a zero offset.

Top module: `vc_cache`

## Requirements
- R1: After reset, cpu_ack, cs_ack, fl_busy and mem_valid are low and the enable flag reads 0 (control-port select 1, bit 0).
- R2: With cs_sel=0 a tag reads and writes as a 32-bit word with the context ID in bits 24:22, write permission in bit 21, supervisor in bit 20, valid in bit 19 and the tag ID in bits 15:2. All other bits are written as don't-care and read as zero.
- R3: A lookup hits only when the line is valid, its tag ID equals the address tag ID and its context equals cpu_ctx. A context mismatch is treated as a miss and refilled.
- R4: A read miss while enabled issues four single-word memory reads to line base +0, +4, +8 and +12, in that order. It returns the requested word and writes the tag with cpu_ctx, cpu_pte_w, cpu_pte_s and valid set.
- R5: A read hit returns the cached word with no memory traffic.
- R6: Every non-faulting store makes exactly one memory write with the same word address, data and byte enables. A store hit also merges the enabled bytes into the cached line.
- R7: A store miss while enabled clears the valid flag of the line resident at that index and allocates nothing, so a later read of the evicted address refills.
- R8: A user-mode access (cpu_super=0) to a supervisor line, or a store to a line without write permission, completes with cpu_fault=1 and with no memory access and no tag change. The flags come from the tag on a hit and from cpu_pte_s/cpu_pte_w on a miss.
- R9: While the enable flag is 0, a read makes one single-word memory read and returns its data, a store makes one memory write, and no tag changes.
- R10: Flush mode 0 invalidates every valid line whose context equals the cpu_ctx value sampled at fl_start.
- R11: Flush mode 1 (segment) also requires the rebuilt line address to match fl_addr from bit SEG_SH upward. Mode 2 (page) requires a match from bit PG_SH upward. Mode 3 invalidates nothing.
- R12: A flush keeps fl_busy high for exactly 2^IDX_W cycles. A processor request raised meanwhile is not acknowledged until fl_busy falls.
- R13: Once mem_valid is raised, it stays high with mem_addr and mem_we stable until mem_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until cpu_ack |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Virtual byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte enables |
| cpu_super | input | 1 | Access made in supervisor mode |
| cpu_ctx | input | 3 | Current context number |
| cpu_pte_w | input | 1 | Write permission from the page mapping |
| cpu_pte_s | input | 1 | Supervisor-only flag from the page mapping |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_fault | output | 1 | Protection fault, valid with cpu_ack |
| cpu_rdata | output | 32 | Load data, valid with cpu_ack |
| cs_req | input | 1 | Control-port request, held until cs_ack |
| cs_we | input | 1 | Control-port write |
| cs_sel | input | 1 | 0 = tag word, 1 = enable flag |
| cs_idx | input | IDX_W | Tag index for cs_sel=0 |
| cs_wdata | input | 32 | Control-port write data |
| cs_ack | output | 1 | One-cycle completion pulse |
| cs_rdata | output | 32 | Control-port read data |
| fl_start | input | 1 | Start a flush (accepted when idle) |
| fl_kind | input | 2 | 0 context, 1 segment, 2 page, 3 none |
| fl_addr | input | 32 | Address selecting the segment or page |
| fl_busy | output | 1 | Flush in progress |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory write byte enables |
| mem_ready | input | 1 | Memory accepts/completes the request |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |

## Verification
The hardest case to reach from the ports is a flush that must tell apart lines of the same context that differ only in segment or page. Ordinary traffic would need many refills to build such a set. So the stimulus plants tag words through the control port: same-context lines in distinct pages and segments, plus a line of another context. It then runs page, segment, context and no-op flushes and reads every tag back after each one. The stall rule is exercised by raising a load during a flush and counting busy cycles before the acknowledge. The store-miss eviction is reached by a load/store/load sequence on two addresses that share an index.

// File: rtl/vc_pkg.sv
package vc_pkg;
  localparam int CTX_W = 3;
  localparam int TID_W = 14;

  typedef struct packed {
    logic [CTX_W-1:0] ctx;
    logic             wr_ok;
    logic             sup;
    logic             vld;
    logic [TID_W-1:0] tid;
  } tag_t;

  typedef enum logic [1:0] {
    FL_CTX  = 2'd0,
    FL_SEG  = 2'd1,
    FL_PAGE = 2'd2,
    FL_NONE = 2'd3
  } fl_kind_e;

  function automatic logic [31:0] tag_to_word(tag_t t);
    return {7'd0, t.ctx, t.wr_ok, t.sup, t.vld, 3'd0, t.tid, 2'd0};
  endfunction

  function automatic tag_t word_to_tag(logic [31:0] w);
    tag_t t;
    t.ctx   = w[24:22];
    t.wr_ok = w[21];
    t.sup   = w[20];
    t.vld   = w[19];
    t.tid   = w[15:2];
    return t;
  endfunction
endpackage

// File: rtl/vc_tag_array.sv
module vc_tag_array import vc_pkg::*; #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  tag_t             wdata,
  input  logic [IDX_W-1:0] raddr,
  output tag_t             rdata
);
  localparam int LINES = 1 << IDX_W;

  tag_t mem [LINES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/vc_data_array.sv
module vc_data_array #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [3:0]    be,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  localparam int DEPTH = 1 << AW;

  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < 4; b++) begin
        if (be[b]) mem[waddr][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/vc_flush_walk.sv
module vc_flush_walk import vc_pkg::*; #(
  parameter int IDX_W  = 6,
  parameter int OFS_W  = 4,
  parameter int PG_SH  = 12,
  parameter int SEG_SH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       kind,
  input  logic [CTX_W-1:0] ctx,
  input  logic [31:0]      addr,
  input  tag_t             cur_tag,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             inv
);
  localparam int LVA_W = TID_W + IDX_W + OFS_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'((1 << IDX_W) - 1);

  fl_kind_e         k_q;
  logic [CTX_W-1:0] c_q;
  logic [LVA_W-1:0] a_q;
  logic [LVA_W-1:0] lva;
  logic             sel;
  logic             unused_bits;

  assign unused_bits = ^{addr[31:LVA_W], cur_tag.wr_ok, cur_tag.sup};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      idx  <= '0;
      k_q  <= FL_NONE;
      c_q  <= '0;
      a_q  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
        k_q  <= fl_kind_e'(kind);
        c_q  <= ctx;
        a_q  <= addr[LVA_W-1:0];
      end
    end else begin
      if (idx == LAST) busy <= 1'b0;
      idx <= idx + 1'b1;
    end
  end

  assign lva = {cur_tag.tid, idx, OFS_W'(0)};

  always_comb begin
    unique case (k_q)
      FL_CTX:  sel = 1'b1;
      FL_SEG:  sel = (lva[LVA_W-1:SEG_SH] == a_q[LVA_W-1:SEG_SH]);
      FL_PAGE: sel = (lva[LVA_W-1:PG_SH] == a_q[LVA_W-1:PG_SH]);
      default: sel = 1'b0;
    endcase
  end

  assign inv = busy && cur_tag.vld && (cur_tag.ctx == c_q) && sel;

  // R12: the walk visits consecutive indices, one per clock
  a_r12_step: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (idx == $past(idx) + 1'b1));
endmodule

// File: rtl/vc_cache.sv
module vc_cache import vc_pkg::*; #(
  parameter int IDX_W  = 6,
  parameter int OFS_W  = 4,
  parameter int PG_SH  = 12,
  parameter int SEG_SH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_req,
  input  logic             cpu_we,
  input  logic [31:0]      cpu_addr,
  input  logic [31:0]      cpu_wdata,
  input  logic [3:0]       cpu_be,
  input  logic             cpu_super,
  input  logic [CTX_W-1:0] cpu_ctx,
  input  logic             cpu_pte_w,
  input  logic             cpu_pte_s,
  output logic             cpu_ack,
  output logic             cpu_fault,
  output logic [31:0]      cpu_rdata,
  input  logic             cs_req,
  input  logic             cs_we,
  input  logic             cs_sel,
  input  logic [IDX_W-1:0] cs_idx,
  input  logic [31:0]      cs_wdata,
  output logic             cs_ack,
  output logic [31:0]      cs_rdata,
  input  logic             fl_start,
  input  logic [1:0]       fl_kind,
  input  logic [31:0]      fl_addr,
  output logic             fl_busy,
  output logic             mem_valid,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  output logic [3:0]       mem_be,
  input  logic             mem_ready,
  input  logic [31:0]      mem_rdata
);
  localparam int BEAT_W = OFS_W - 2;
  localparam int TID_LO = OFS_W + IDX_W;
  localparam logic [BEAT_W-1:0] BEAT_LAST = BEAT_W'((1 << BEAT_W) - 1);

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_MEM, S_RESP} st_e;

  st_e               st;
  logic              ctrl_en;
  logic [BEAT_W-1:0] beat;
  logic [IDX_W-1:0]  idx, fl_idx, tag_ra, tag_wa;
  logic [BEAT_W-1:0] wsel;
  logic [TID_W-1:0]  tid;
  tag_t              cur, tag_wd;
  logic              tag_we, fl_inv, fl_go;
  logic              dat_we;
  logic [3:0]        dat_be;
  logic [IDX_W+BEAT_W-1:0] dat_wa;
  logic [31:0]       dat_wd, dat_rd;
  logic              idle, take_cpu, hit, eff_sup, eff_w, fault, hs;
  logic              unused_lo;

  assign unused_lo = ^cpu_addr[1:0];

  assign idx  = cpu_addr[OFS_W +: IDX_W];
  assign wsel = cpu_addr[2 +: BEAT_W];
  assign tid  = cpu_addr[TID_LO +: TID_W];
  assign hs   = mem_valid && mem_ready;

  assign fl_go    = fl_start && (st == S_IDLE) && !fl_busy;
  assign idle     = (st == S_IDLE) && !fl_busy && !fl_start;
  assign take_cpu = idle && !cs_req && cpu_req;

  assign tag_ra = fl_busy ? fl_idx : ((st == S_IDLE && cs_req) ? cs_idx : idx);

  assign hit     = ctrl_en && cur.vld && (cur.tid == tid) && (cur.ctx == cpu_ctx);
  assign eff_sup = hit ? cur.sup   : cpu_pte_s;
  assign eff_w   = hit ? cur.wr_ok : cpu_pte_w;
  assign fault   = (eff_sup && !cpu_super) || (cpu_we && !eff_w);

  vc_tag_array #(.IDX_W(IDX_W)) u_tags (
    .clk(clk), .we(tag_we), .waddr(tag_wa), .wdata(tag_wd),
    .raddr(tag_ra), .rdata(cur)
  );

  vc_data_array #(.AW(IDX_W + BEAT_W)) u_data (
    .clk(clk), .we(dat_we), .be(dat_be), .waddr(dat_wa), .wdata(dat_wd),
    .raddr({idx, wsel}), .rdata(dat_rd)
  );

  vc_flush_walk #(.IDX_W(IDX_W), .OFS_W(OFS_W), .PG_SH(PG_SH), .SEG_SH(SEG_SH)) u_walk (
    .clk(clk), .rst(rst), .start(fl_go), .kind(fl_kind), .ctx(cpu_ctx),
    .addr(fl_addr), .cur_tag(cur), .busy(fl_busy), .idx(fl_idx), .inv(fl_inv)
  );

  // tag write source select
  always_comb begin
    tag_we = 1'b0;
    tag_wa = idx;
    tag_wd = cur;
    if (fl_inv) begin
      tag_we     = 1'b1;
      tag_wa     = fl_idx;
      tag_wd.vld = 1'b0;
    end else if (idle && cs_req && cs_we && !cs_sel) begin
      tag_we = 1'b1;
      tag_wa = cs_idx;
      tag_wd = word_to_tag(cs_wdata);
    end else if (take_cpu && cpu_we && ctrl_en && !fault && !hit && cur.vld) begin
      tag_we     = 1'b1;
      tag_wd.vld = 1'b0;
    end else if (st == S_FILL && hs && beat == BEAT_LAST) begin
      tag_we       = 1'b1;
      tag_wd.ctx   = cpu_ctx;
      tag_wd.wr_ok = cpu_pte_w;
      tag_wd.sup   = cpu_pte_s;
      tag_wd.vld   = 1'b1;
      tag_wd.tid   = tid;
    end
  end

  // data write source select
  always_comb begin
    dat_we = 1'b0;
    dat_be = 4'hF;
    dat_wa = {idx, wsel};
    dat_wd = cpu_wdata;
    if (st == S_FILL && hs) begin
      dat_we = 1'b1;
      dat_wa = {idx, beat};
      dat_wd = mem_rdata;
    end else if (take_cpu && cpu_we && hit && !fault) begin
      dat_we = 1'b1;
      dat_be = cpu_be;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      ctrl_en   <= 1'b0;
      beat      <= '0;
      cpu_ack   <= 1'b0;
      cpu_fault <= 1'b0;
      cpu_rdata <= '0;
      cs_ack    <= 1'b0;
      cs_rdata  <= '0;
      mem_valid <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_be    <= '0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (idle && cs_req) begin
            cs_ack <= 1'b1;
            if (cs_sel) begin
              cs_rdata <= {31'd0, ctrl_en};
              if (cs_we) ctrl_en <= cs_wdata[0];
            end else begin
              cs_rdata <= tag_to_word(cur);
            end
            st <= S_RESP;
          end else if (take_cpu) begin
            if (fault) begin
              cpu_ack   <= 1'b1;
              cpu_fault <= 1'b1;
              st        <= S_RESP;
            end else if (cpu_we) begin
              mem_valid <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= {cpu_addr[31:2], 2'b00};
              mem_wdata <= cpu_wdata;
              mem_be    <= cpu_be;
              st        <= S_MEM;
            end else if (hit) begin
              cpu_rdata <= dat_rd;
              cpu_ack   <= 1'b1;
              st        <= S_RESP;
            end else begin
              mem_valid <= 1'b1;
              mem_we    <= 1'b0;
              mem_be    <= 4'hF;
              if (ctrl_en) begin
                mem_addr <= {cpu_addr[31:OFS_W], OFS_W'(0)};
                beat     <= '0;
                st       <= S_FILL;
              end else begin
                mem_addr <= {cpu_addr[31:2], 2'b00};
                st       <= S_MEM;
              end
            end
          end
        end
        S_FILL: begin
          if (hs) begin
            if (beat == wsel) cpu_rdata <= mem_rdata;
            if (beat == BEAT_LAST) begin
              mem_valid <= 1'b0;
              cpu_ack   <= 1'b1;
              st        <= S_RESP;
            end else begin
              beat     <= beat + 1'b1;
              mem_addr <= mem_addr + 32'd4;
            end
          end
        end
        S_MEM: begin
          if (hs) begin
            mem_valid <= 1'b0;
            if (!mem_we) cpu_rdata <= mem_rdata;
            cpu_ack <= 1'b1;
            st      <= S_RESP;
          end
        end
        default: begin
          cpu_ack   <= 1'b0;
          cpu_fault <= 1'b0;
          cs_ack    <= 1'b0;
          st        <= S_IDLE;
        end
      endcase
    end
  end

  // R13: a memory request is held unchanged until accepted
  a_r13_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

  // R8: a faulting access completes without any memory request
  a_r8_fault_quiet: assert property (@(posedge clk) disable iff (rst)
    cpu_fault |-> (cpu_ack && !mem_valid));

  // R12: nothing reaches the processor or memory while the flush walks
  a_r12_stall: assert property (@(posedge clk) disable iff (rst)
    fl_busy |-> (!cpu_ack && !mem_valid));

  // R1: completions and the flush never overlap
  a_r1_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cpu_ack, cs_ack, fl_busy}));

  // R9: with the cache off, only software or the flush touch tags
  a_r9_bypass: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_en && tag_we) |-> (fl_busy || cs_req));
endmodule

// File: tb/sim_vc_cache.sv
module sim_vc_cache;
  localparam int IDX_W = 6;
  localparam int LINES = 1 << IDX_W;

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] wd;
    logic [3:0]  be;
    logic [2:0]  nrd;
    logic        nwr;
  } op_t;

  // context 1, user mode, writable, non-supervisor page
  localparam op_t OPS [8] = '{
    '{1'b0, 32'h0000_0100, 32'h0,         4'h0, 3'd4, 1'b0},
    '{1'b0, 32'h0000_0104, 32'h0,         4'h0, 3'd0, 1'b0},
    '{1'b1, 32'h0000_0108, 32'hDEAD_BEEF, 4'h3, 3'd0, 1'b1},
    '{1'b0, 32'h0000_0108, 32'h0,         4'h0, 3'd0, 1'b0},
    '{1'b0, 32'h0000_0500, 32'h0,         4'h0, 3'd4, 1'b0},
    '{1'b1, 32'h0000_0100, 32'h1234_5678, 4'hF, 3'd0, 1'b1},
    '{1'b0, 32'h0000_0500, 32'h0,         4'h0, 3'd4, 1'b0},
    '{1'b0, 32'h0000_050C, 32'h0,         4'h0, 3'd0, 1'b0}
  };
  string op_req [8] = '{"R4", "R5", "R6", "R6", "R3", "R7", "R7", "R5"};

  logic clk = 1'b0, rst = 1'b1;
  logic cpu_req = 0, cpu_we = 0, cpu_super = 0, cpu_pte_w = 0, cpu_pte_s = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0;
  logic [3:0] cpu_be = 0;
  logic [2:0] cpu_ctx = 0;
  logic cpu_ack, cpu_fault;
  logic [31:0] cpu_rdata;
  logic cs_req = 0, cs_we = 0, cs_sel = 0;
  logic [IDX_W-1:0] cs_idx = 0;
  logic [31:0] cs_wdata = 0;
  logic cs_ack;
  logic [31:0] cs_rdata;
  logic fl_start = 0;
  logic [1:0] fl_kind = 0;
  logic [31:0] fl_addr = 0;
  logic fl_busy;
  logic mem_valid, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0] mem_be;
  logic mem_ready = 0;
  logic [31:0] mem_rdata = 0;

  int checks = 0, errs = 0, cyc = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [31:0] rd_log [16];
  logic [31:0] last_wa, last_wd;
  logic [3:0]  last_be;
  logic [31:0] bmem [1024];

  always #5 clk = ~clk;

  vc_cache #(.IDX_W(IDX_W)) u0 (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_be(cpu_be), .cpu_super(cpu_super), .cpu_ctx(cpu_ctx), .cpu_pte_w(cpu_pte_w),
    .cpu_pte_s(cpu_pte_s), .cpu_ack(cpu_ack), .cpu_fault(cpu_fault), .cpu_rdata(cpu_rdata),
    .cs_req(cs_req), .cs_we(cs_we), .cs_sel(cs_sel), .cs_idx(cs_idx), .cs_wdata(cs_wdata),
    .cs_ack(cs_ack), .cs_rdata(cs_rdata),
    .fl_start(fl_start), .fl_kind(fl_kind), .fl_addr(fl_addr), .fl_busy(fl_busy),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  // memory model: one wait cycle, then ready for one cycle
  always @(negedge clk) begin
    if (mem_ready) begin
      mem_ready <= 1'b0;
    end else if (mem_valid) begin
      mem_ready <= 1'b1;
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) bmem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        last_wa <= mem_addr;
        last_wd <= mem_wdata;
        last_be <= mem_be;
        wr_cnt  <= wr_cnt + 1;
      end else begin
        mem_rdata <= bmem[mem_addr[11:2]];
        rd_log[rd_cnt % 16] <= mem_addr;
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errs = errs + 1;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end

  task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", r, got, exp);
    end
  endtask

  function automatic logic [31:0] tw(input int ctx, input int w, input int s, input int v, input int tid);
    return (ctx << 22) | (w << 21) | (s << 20) | (v << 19) | (tid << 2);
  endfunction

  task automatic cs_op(input logic we, input logic sel, input int ix, input logic [31:0] d,
                       output logic [31:0] rd);
    int n = 0;
    @(negedge clk);
    cs_req = 1; cs_we = we; cs_sel = sel; cs_idx = IDX_W'(ix); cs_wdata = d;
    do begin @(negedge clk); n++; end while (!cs_ack && n < 500);
    rd = cs_rdata;
    cs_req = 0; cs_we = 0;
    @(negedge clk);
  endtask

  task automatic cpu_op(input logic we, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] be, input logic sup, input logic [2:0] ctx,
                        input logic pw, input logic ps,
                        output logic [31:0] rd, output logic flt, output int nrd, output int nwr);
    int r0, w0, n = 0;
    @(negedge clk);
    r0 = rd_cnt; w0 = wr_cnt;
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_be = be;
    cpu_super = sup; cpu_ctx = ctx; cpu_pte_w = pw; cpu_pte_s = ps;
    do begin @(negedge clk); n++; end while (!cpu_ack && n < 500);
    rd = cpu_rdata; flt = cpu_fault;
    cpu_req = 0; cpu_we = 0;
    @(negedge clk);
    @(negedge clk);
    nrd = rd_cnt - r0; nwr = wr_cnt - w0;
  endtask

  task automatic flush(input logic [1:0] kind, input logic [2:0] ctx, input logic [31:0] a);
    int n = 0;
    @(negedge clk);
    fl_kind = kind; fl_addr = a; cpu_ctx = ctx; fl_start = 1;
    @(negedge clk);
    fl_start = 0;
    while (fl_busy && n < 10000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd, expd;
    logic flt;
    int nrd, nwr, busy_n, early;

    for (int i = 0; i < 1024; i++) bmem[i] = 32'hC0DE_0000 ^ (i * 32'h0001_0101);

    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 cpu_ack", {31'd0, cpu_ack}, 32'd0);
    chk("R1 fl_busy", {31'd0, fl_busy}, 32'd0);
    chk("R1 mem_valid", {31'd0, mem_valid}, 32'd0);
    cs_op(0, 1, 0, 0, rd);
    chk("R1 enable", rd, 32'd0);

    // R2: reserved bits read back as zero
    cs_op(1, 0, 5, 32'hFFFF_FFFF, rd);
    cs_op(0, 0, 5, 0, rd);
    chk("R2 tag word", rd, 32'h01F8_FFFC);

    for (int i = 0; i < LINES; i++) cs_op(1, 0, i, 32'h0, rd);
    cs_op(1, 1, 0, 32'h1, rd);
    cs_op(0, 1, 0, 0, rd);
    chk("R9 enable set", rd, 32'd1);

    // table-driven processor sequence
    for (int k = 0; k < 8; k++) begin
      expd = bmem[OPS[k].addr[11:2]];
      cpu_op(OPS[k].we, OPS[k].addr, OPS[k].wd, OPS[k].be, 1'b0, 3'd1, 1'b1, 1'b0,
             rd, flt, nrd, nwr);
      chk(op_req[k], {31'd0, flt}, 32'd0);
      chk(op_req[k], nrd, OPS[k].nrd);
      chk(op_req[k], nwr, {31'd0, OPS[k].nwr});
      if (OPS[k].we) begin
        chk("R6 addr", last_wa, OPS[k].addr);
        chk("R6 data", last_wd, OPS[k].wd);
        chk("R6 be", {28'd0, last_be}, {28'd0, OPS[k].be});
      end else begin
        chk(op_req[k], rd, expd);
      end
      if (k == 0) begin
        for (int b = 0; b < 4; b++) chk("R4 fill order", rd_log[b], 32'h100 + 32'(b * 4));
        cs_op(0, 0, 'h10, 0, rd);
        chk("R4 fill tag", rd, tw(1, 1, 0, 1, 0));
      end
    end

    // R3: context mismatch refills and retags
    expd = bmem['h504 >> 2];
    cpu_op(0, 32'h504, 0, 0, 0, 3'd2, 1, 0, rd, flt, nrd, nwr);
    chk("R3 ctx miss reads", nrd, 4);
    chk("R3 ctx miss data", rd, expd);
    cs_op(0, 0, 'h10, 0, rd);
    chk("R3 retag", rd, tw(2, 1, 0, 1, 1));

    // R8: protection
    cs_op(1, 0, 'h20, tw(2, 0, 1, 1, 0), rd);
    cpu_op(0, 32'h200, 0, 0, 0, 3'd2, 1, 0, rd, flt, nrd, nwr);
    chk("R8 user to supervisor line", {31'd0, flt}, 32'd1);
    chk("R8 no read", nrd, 0);
    cpu_op(1, 32'h204, 32'h55, 4'hF, 1, 3'd2, 1, 0, rd, flt, nrd, nwr);
    chk("R8 store to read-only line", {31'd0, flt}, 32'd1);
    chk("R8 no write", nwr, 0);
    cpu_op(0, 32'h200, 0, 0, 1, 3'd2, 1, 0, rd, flt, nrd, nwr);
    chk("R8 supervisor hit ok", {31'd0, flt}, 32'd0);
    chk("R5 supervisor hit no read", nrd, 0);
    cpu_op(0, 32'h300, 0, 0, 0, 3'd2, 1, 1, rd, flt, nrd, nwr);
    chk("R8 miss uses request flags", {31'd0, flt}, 32'd1);
    chk("R8 miss no read", nrd, 0);
    cs_op(0, 0, 'h30, 0, rd);
    chk("R8 miss tag untouched", rd, 32'd0);
    cs_op(0, 0, 'h20, 0, rd);
    chk("R8 hit tag untouched", rd, tw(2, 0, 1, 1, 0));

    // flush set-up: three lines of context 3, one of context 4
    cs_op(1, 0, 1, tw(3, 1, 0, 1, 1), rd);
    cs_op(1, 0, 2, tw(3, 1, 0, 1, 8), rd);
    cs_op(1, 0, 3, tw(3, 1, 0, 1, 'h100), rd);
    cs_op(1, 0, 4, tw(4, 1, 0, 1, 8), rd);

    // R11 page flush with a stalled load raised during the walk (R12)
    @(negedge clk);
    fl_kind = 2'd2; fl_addr = 32'h2000; cpu_ctx = 3'd3; fl_start = 1;
    @(negedge clk);
    fl_start = 0;
    cpu_req = 1; cpu_we = 0; cpu_addr = 32'h504; cpu_ctx = 3'd2;
    cpu_super = 0; cpu_pte_w = 1; cpu_pte_s = 0;
    busy_n = 0; early = 0;
    for (int n = 0; n < 2000 && !cpu_ack; n++) begin
      if (fl_busy) busy_n++;
      @(negedge clk);
    end
    if (fl_busy) early = 1;
    chk("R12 ack after busy", {31'd0, cpu_ack}, 32'd1);
    chk("R12 no ack while busy", early, 0);
    cpu_req = 0;
    @(negedge clk);
    chk("R12 busy cycles", busy_n, LINES);
    cs_op(0, 0, 2, 0, rd); chk("R11 page hit", rd, tw(3, 1, 0, 0, 8));
    cs_op(0, 0, 1, 0, rd); chk("R11 page other", rd, tw(3, 1, 0, 1, 1));
    cs_op(0, 0, 3, 0, rd); chk("R11 page other", rd, tw(3, 1, 0, 1, 'h100));
    cs_op(0, 0, 4, 0, rd); chk("R11 page other ctx", rd, tw(4, 1, 0, 1, 8));

    flush(2'd1, 3'd3, 32'h0004_0000);
    cs_op(0, 0, 3, 0, rd); chk("R11 seg hit", rd, tw(3, 1, 0, 0, 'h100));
    cs_op(0, 0, 1, 0, rd); chk("R11 seg other", rd, tw(3, 1, 0, 1, 1));

    flush(2'd3, 3'd3, 32'h0);
    cs_op(0, 0, 1, 0, rd); chk("R11 mode 3 none", rd, tw(3, 1, 0, 1, 1));

    flush(2'd0, 3'd3, 32'h0);
    cs_op(0, 0, 1, 0, rd); chk("R10 ctx flush", rd, tw(3, 1, 0, 0, 1));
    cs_op(0, 0, 4, 0, rd); chk("R10 other ctx kept", rd, tw(4, 1, 0, 1, 8));
    cs_op(0, 0, 'h10, 0, rd); chk("R10 other ctx kept", rd, tw(2, 1, 0, 1, 1));

    // R9: disabled cache bypasses
    cs_op(1, 1, 0, 32'h0, rd);
    expd = bmem['h504 >> 2];
    cpu_op(0, 32'h504, 0, 0, 0, 3'd2, 1, 0, rd, flt, nrd, nwr);
    chk("R9 bypass read count", nrd, 1);
    chk("R9 bypass data", rd, expd);
    chk("R9 bypass addr", rd_log[(rd_cnt - 1) % 16], 32'h504);
    cpu_op(1, 32'h50C, 32'hA5A5_5A5A, 4'hF, 0, 3'd2, 1, 0, rd, flt, nrd, nwr);
    chk("R9 bypass write", nwr, 1);
    cpu_op(0, 32'h700, 0, 0, 0, 3'd2, 1, 0, rd, flt, nrd, nwr);
    chk("R9 bypass miss count", nrd, 1);
    cs_op(0, 0, 'h10, 0, rd); chk("R9 tag untouched", rd, tw(2, 1, 0, 1, 1));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule